// File: doc/BRIEF.md
# HDLC Receive Frame Status Tracker

This block follows the frames that an HDLC deframer stores, byte by byte, into a receive byte FIFO. It always reports on the oldest frame that has not yet been fully read. The deframer signals each byte written. It marks the byte that ends a frame, and on that byte it also reports whether the frame was aborted, failed its FCS check, or held a bit count that was not a whole number of octets. It also tags any byte that belongs to the FCS. A processor-side reader pops bytes from the FIFO one at a time.

The tracker keeps a queue of frame descriptors, with one entry for each frame present in the FIFO. From the head entry it builds three outputs. The first is a compact status word holding the end-seen bit, a corrupted bit, the size modulo 32 and a nearly-drained bit. The second is a detail vector holding each corruption cause separately. The third is the frame size modulo 128, which leaves out FCS bytes when FCS stripping is configured. When the last byte of a closed head frame is popped, its descriptor retires, and the next frame's status shows from the following clock. A new frame that finds the queue full marks the head frame as overwritten, and the tracker does not follow the new frame.

Top module: `hdlc_rx_frame_status`

## Requirements
- R1: After reset, and whenever no frame is tracked, st_valid is 0 and st_word, st_detail and st_size128 are all zero.
- R2: st_word bit 7 is the end-seen bit of the head frame. Bits 5:1 hold the count of all bytes written for it, modulo 32. Bit 0 is 1 when fewer than 32 of its bytes are still unread.
- R3: st_detail bit 0 is abort, bit 1 is FCS failure, bit 2 is not a whole octet, bit 3 is overwritten, and bit 4 is end-seen. Abort, FCS failure and not-octet are taken from the qualifiers on the byte that carries wr_last.
- R4: st_word bit 6 (corrupted) is 1 exactly when any of the four cause bits of the head frame is 1.
- R5: st_size128 counts the bytes of the head frame modulo 128. A byte flagged wr_is_fcs is left out when cfg_fcs_strip was 1 as that byte was written.
- R6: The first byte written while no frame is open starts a new frame, and the byte with wr_last ends it. Each byte write shows in the outputs on the clock after it is written. With no write and no pop, the outputs hold.
- R7: A pop lowers the head frame's unread count by one. A pop is ignored when no frame is tracked or when the head frame has no unread bytes.
- R8: A pop of the last unread byte of a head frame that has ended retires that frame. The following frame's status appears on the next clock.
- R9: At most 8 frames are tracked. A frame that starts while 8 are held sets the overwritten bit of the head frame, and its bytes up to and including its wr_last byte are not tracked.
- R10: wr_abort, wr_fcs_bad and wr_not_octet have no effect on bytes written without wr_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fcs_strip | input | 1 | 1: FCS-tagged bytes are excluded from the modulo-128 size |
| wr_valid | input | 1 | One byte written to the FIFO this cycle |
| wr_last | input | 1 | The written byte ends its frame (closing flag or abort) |
| wr_abort | input | 1 | Frame ended by abort (valid with wr_last) |
| wr_fcs_bad | input | 1 | FCS check failed (valid with wr_last) |
| wr_not_octet | input | 1 | Flag-to-flag bit count not a multiple of 8 (valid with wr_last) |
| wr_is_fcs | input | 1 | The written byte is an FCS byte |
| rd_pop | input | 1 | Reader removes one byte from the FIFO |
| st_valid | output | 1 | A head frame is tracked |
| st_word | output | 8 | Head status: end-seen, corrupted, size mod 32, fewer than 32 unread |
| st_detail | output | 5 | Head causes and end-seen bit |
| st_size128 | output | 7 | Head size modulo 128 |

## Verification
The assertions assume that the deframer sends the qualifiers only with a byte write. They also assume the reader pops only bytes that are present, so a pop against an empty head must leave the outputs empty. The assertions rely on the write side never allocating a descriptor while the queue is full. The stimulus drives qualifier bits on bytes that do not end a frame, so that the rule ignoring them is exercised. Random write and pop rates are chosen so that the queue fills often and overwrite marking occurs. Frame lengths stay far below the width of the unread counter.

// File: rtl/hfst_pkg.sv
package hfst_pkg;
    localparam int unsigned SZ_LO_W = 5;   // modulo-32 size field
    localparam int unsigned SZ_HI_W = 7;   // modulo-128 size field
    localparam int unsigned NEAR_EMPTY = 32;

    typedef struct packed {
        logic ovfl;
        logic not_octet;
        logic fcs_bad;
        logic abort;
    } cause_t;

    typedef struct packed {
        logic last;
        logic abort;
        logic fcs_bad;
        logic not_octet;
        logic is_fcs;
    } wr_qual_t;

    typedef struct packed {
        logic               closed;
        cause_t             cause;
        logic [SZ_LO_W-1:0] sz_lo;
        logic [SZ_HI_W-1:0] sz_hi;
    } desc_t;

    // Fold one written byte into a descriptor.
    function automatic desc_t desc_add(desc_t d, wr_qual_t q, logic strip);
        desc_t n;
        n       = d;
        n.sz_lo = d.sz_lo + 1'b1;
        if (!(strip && q.is_fcs)) n.sz_hi = d.sz_hi + 1'b1;
        if (q.last) begin
            n.closed          = 1'b1;
            n.cause.abort     = d.cause.abort | q.abort;
            n.cause.fcs_bad   = d.cause.fcs_bad | q.fcs_bad;
            n.cause.not_octet = d.cause.not_octet | q.not_octet;
        end
        return n;
    endfunction

    function automatic logic is_corrupt(cause_t c);
        return c.abort | c.fcs_bad | c.not_octet | c.ovfl;
    endfunction
endpackage

// File: rtl/hfst_wr_ctrl.sv
module hfst_wr_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic wr_valid,
    input  logic wr_last,
    input  logic full,
    output logic alloc,
    output logic upd,
    output logic mark_ovfl
);
    logic in_frm;
    logic drop;

    always_comb begin
        alloc     = 1'b0;
        upd       = 1'b0;
        mark_ovfl = 1'b0;
        if (wr_valid) begin
            if (in_frm)     upd       = 1'b1;
            else if (!drop) begin
                if (full)   mark_ovfl = 1'b1;
                else        alloc     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frm <= 1'b0;
            drop   <= 1'b0;
        end else if (wr_valid) begin
            if (in_frm)      in_frm <= !wr_last;
            else if (drop)   drop   <= !wr_last;
            else if (full)   drop   <= !wr_last;
            else             in_frm <= !wr_last;
        end
    end

    p_mode_excl_r9: assert property (@(posedge clk) disable iff (rst) !(in_frm && drop))
        else $error("open and dropped frame at once");
endmodule

// File: rtl/hfst_desc_queue.sv
module hfst_desc_queue #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned REM_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strip,
    input  logic                alloc,
    input  logic                upd,
    input  logic                mark_ovfl,
    input  hfst_pkg::wr_qual_t  qual,
    input  logic                rd_pop,
    output logic                full,
    output logic                head_valid,
    output hfst_pkg::desc_t     head_desc,
    output logic [REM_W-1:0]    head_rem
);
    import hfst_pkg::*;
    localparam int unsigned IW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    desc_t            dq [DEPTH];
    desc_t            dn [DEPTH];
    logic [REM_W-1:0] rq [DEPTH];
    logic [REM_W-1:0] rn [DEPTH];
    logic [IW-1:0]    rp, wp, open_idx;
    logic [CW-1:0]    cnt;
    logic             pop_ok, retire;

    function automatic logic [IW-1:0] ptr_inc(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign open_idx   = (wp == '0) ? IW'(DEPTH - 1) : wp - 1'b1;
    assign full       = (cnt == CW'(DEPTH));
    assign head_valid = (cnt != '0);
    assign head_desc  = dq[rp];
    assign head_rem   = rq[rp];
    assign pop_ok     = rd_pop && head_valid && (rq[rp] != '0);
    assign retire     = pop_ok && dq[rp].closed && (rq[rp] == REM_W'(1));

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            dn[i] = dq[i];
            rn[i] = rq[i];
            if (alloc && wp == IW'(i)) begin
                dn[i] = desc_add('0, qual, strip);
                rn[i] = REM_W'(1);
            end else if (upd && open_idx == IW'(i)) begin
                dn[i] = desc_add(dq[i], qual, strip);
                rn[i] = rq[i] + 1'b1;
            end
            if (mark_ovfl && rp == IW'(i)) dn[i].cause.ovfl = 1'b1;
            if (pop_ok && rp == IW'(i))    rn[i] = rn[i] - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                dq[i] <= '0;
                rq[i] <= '0;
            end
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                dq[i] <= dn[i];
                rq[i] <= rn[i];
            end
            if (alloc)  wp <= ptr_inc(wp);
            if (retire) rp <= ptr_inc(rp);
            case ({alloc, retire})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_alloc_room_r9: assert property (@(posedge clk) disable iff (rst) alloc |-> !full)
        else $error("descriptor allocated into full queue");
    p_ovfl_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (mark_ovfl && !retire) |=> head_desc.cause.ovfl)
        else $error("overwrite not marked on head");
    p_pop_dec_r7: assert property (@(posedge clk) disable iff (rst)
        (pop_ok && !retire && !(upd && open_idx == rp)) |=> head_rem == REM_W'($past(head_rem) - 1'b1))
        else $error("pop did not lower unread count");
endmodule

// File: rtl/hfst_status_fmt.sv
module hfst_status_fmt #(
    parameter int unsigned REM_W = 12
) (
    input  logic                head_valid,
    input  hfst_pkg::desc_t     head_desc,
    input  logic [REM_W-1:0]    head_rem,
    output logic                st_valid,
    output logic [7:0]          st_word,
    output logic [4:0]          st_detail,
    output logic [6:0]          st_size128
);
    import hfst_pkg::*;
    logic near_empty;

    assign near_empty = (head_rem < REM_W'(NEAR_EMPTY));
    assign st_valid   = head_valid;

    always_comb begin
        st_word    = '0;
        st_detail  = '0;
        st_size128 = '0;
        if (head_valid) begin
            st_word    = {head_desc.closed, is_corrupt(head_desc.cause),
                          head_desc.sz_lo, near_empty};
            st_detail  = {head_desc.closed, head_desc.cause.ovfl, head_desc.cause.not_octet,
                          head_desc.cause.fcs_bad, head_desc.cause.abort};
            st_size128 = head_desc.sz_hi;
        end
    end
endmodule

// File: rtl/hdlc_rx_frame_status.sv
module hdlc_rx_frame_status #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned REM_W = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_fcs_strip,
    input  logic       wr_valid,
    input  logic       wr_last,
    input  logic       wr_abort,
    input  logic       wr_fcs_bad,
    input  logic       wr_not_octet,
    input  logic       wr_is_fcs,
    input  logic       rd_pop,
    output logic       st_valid,
    output logic [7:0] st_word,
    output logic [4:0] st_detail,
    output logic [6:0] st_size128
);
    import hfst_pkg::*;

    logic             alloc, upd, mark_ovfl, full, head_valid;
    wr_qual_t         qual;
    desc_t            head_desc;
    logic [REM_W-1:0] head_rem;

    assign qual = '{last: wr_last, abort: wr_abort, fcs_bad: wr_fcs_bad,
                    not_octet: wr_not_octet, is_fcs: wr_is_fcs};

    hfst_wr_ctrl u_wr (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_last(wr_last), .full(full),
        .alloc(alloc), .upd(upd), .mark_ovfl(mark_ovfl)
    );

    hfst_desc_queue #(.DEPTH(DEPTH), .REM_W(REM_W)) u_q (
        .clk(clk), .rst(rst), .strip(cfg_fcs_strip), .alloc(alloc), .upd(upd),
        .mark_ovfl(mark_ovfl), .qual(qual), .rd_pop(rd_pop), .full(full),
        .head_valid(head_valid), .head_desc(head_desc), .head_rem(head_rem)
    );

    hfst_status_fmt #(.REM_W(REM_W)) u_fmt (
        .head_valid(head_valid), .head_desc(head_desc), .head_rem(head_rem),
        .st_valid(st_valid), .st_word(st_word), .st_detail(st_detail),
        .st_size128(st_size128)
    );

    p_pop_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !st_valid && !wr_valid) |=> !st_valid)
        else $error("pop on empty tracker changed state");
    p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid && !rd_pop) |=> ($stable(st_word) && $stable(st_detail) && $stable(st_size128)))
        else $error("outputs moved without write or pop");
endmodule

// File: tb/hdlc_rx_frame_status_tb.sv
module hdlc_rx_frame_status_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_fcs_strip = 1'b0;
    logic wr_valid = 0, wr_last = 0, wr_abort = 0, wr_fcs_bad = 0, wr_not_octet = 0, wr_is_fcs = 0;
    logic rd_pop = 0;
    logic       st_valid;
    logic [7:0] st_word;
    logic [4:0] st_detail;
    logic [6:0] st_size128;

    int n_chk = 0, n_fail = 0;
    string cur_tag = "R1";

    int m_rem[$], m_s32[$], m_s128[$];
    bit m_cl[$], m_ab[$], m_fb[$], m_no[$], m_ov[$];
    bit m_in = 0, m_drop = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_frame_status u_dut (
        .clk(clk), .rst(rst), .cfg_fcs_strip(cfg_fcs_strip), .wr_valid(wr_valid),
        .wr_last(wr_last), .wr_abort(wr_abort), .wr_fcs_bad(wr_fcs_bad),
        .wr_not_octet(wr_not_octet), .wr_is_fcs(wr_is_fcs), .rd_pop(rd_pop),
        .st_valid(st_valid), .st_word(st_word), .st_detail(st_detail), .st_size128(st_size128)
    );

    task automatic mdl(bit wv, bit wl, bit wa, bit wf, bit wn, bit wfc, bit pop, bit strip);
        int n = m_rem.size();
        bit pok = pop && n > 0 && m_rem[0] > 0;
        bit ret = pok && m_cl[0] && m_rem[0] == 1;
        if (wv) begin
            if (m_in) begin
                int k = n - 1;
                m_rem[k] = m_rem[k] + 1;
                m_s32[k] = (m_s32[k] + 1) % 32;
                if (!(strip && wfc)) m_s128[k] = (m_s128[k] + 1) % 128;
                if (wl) begin
                    m_cl[k] = 1; m_ab[k] = m_ab[k] | wa; m_fb[k] = m_fb[k] | wf; m_no[k] = m_no[k] | wn;
                    m_in = 0;
                end
            end else if (m_drop) begin
                if (wl) m_drop = 0;
            end else if (n == DEPTH) begin
                m_ov[0] = 1;
                m_drop = !wl;
            end else begin
                m_rem.push_back(1); m_s32.push_back(1); m_s128.push_back((strip && wfc) ? 0 : 1);
                m_cl.push_back(wl); m_ab.push_back(wl & wa); m_fb.push_back(wl & wf);
                m_no.push_back(wl & wn); m_ov.push_back(0);
                m_in = !wl;
            end
        end
        if (pok) begin
            m_rem[0] = m_rem[0] - 1;
            if (ret) begin
                void'(m_rem.pop_front()); void'(m_s32.pop_front()); void'(m_s128.pop_front());
                void'(m_cl.pop_front()); void'(m_ab.pop_front()); void'(m_fb.pop_front());
                void'(m_no.pop_front()); void'(m_ov.pop_front());
            end
        end
    endtask

    task automatic check_out();
        logic [7:0] ew = '0;
        logic [4:0] ed = '0;
        logic [6:0] es = '0;
        logic ev = (m_rem.size() != 0);
        if (ev) begin
            bit cor = m_ab[0] | m_fb[0] | m_no[0] | m_ov[0];
            ew = {m_cl[0], cor, 5'(m_s32[0]), (m_rem[0] < 32)};
            ed = {m_cl[0], m_ov[0], m_no[0], m_fb[0], m_ab[0]};
            es = 7'(m_s128[0]);
        end
        n_chk++;
        if (st_valid !== ev || st_word !== ew || st_detail !== ed || st_size128 !== es) begin
            n_fail++;
            $display("FAIL %s: valid/word/detail/size128 got %b/%h/%b/%0d expected %b/%h/%b/%0d",
                     cur_tag, st_valid, st_word, st_detail, st_size128, ev, ew, ed, es);
        end
    endtask

    // Drive one cycle, starting just after a rising edge; check after the next edge.
    task automatic cyc(bit wv, bit wl, bit wa, bit wf, bit wn, bit wfc, bit pop);
        wr_valid = wv; wr_last = wl; wr_abort = wa; wr_fcs_bad = wf;
        wr_not_octet = wn; wr_is_fcs = wfc; rd_pop = pop;
        mdl(wv, wl, wa, wf, wn, wfc, pop, cfg_fcs_strip);
        @(posedge clk); #1;
        wr_valid = 0; wr_last = 0; wr_abort = 0; wr_fcs_bad = 0;
        wr_not_octet = 0; wr_is_fcs = 0; rd_pop = 0;
        check_out();
    endtask

    // Non-final bytes carry set qualifier bits, which must be ignored (R10).
    task automatic send_frame(int len, int nfcs, bit ab, bit fb, bit no);
        for (int b = 0; b < len; b++) begin
            bit last = (b == len - 1);
            cyc(1, last, last ? ab : 1'b1, last ? fb : 1'b1, last ? no : 1'b1, b >= len - nfcs, 0);
        end
    endtask

    task automatic pop_n(int k);
        for (int j = 0; j < k; j++) cyc(0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        cur_tag = "R1"; check_out();
        pop_n(2);                                   // R7: pops on empty tracker

        cur_tag = "R6";  send_frame(3, 0, 0, 0, 0);
        cur_tag = "R10"; send_frame(5, 0, 0, 0, 0);
        cur_tag = "R5";  cfg_fcs_strip = 1; send_frame(6, 2, 0, 0, 0);
        cfg_fcs_strip = 0; send_frame(6, 2, 0, 0, 0);
        cur_tag = "R3";  send_frame(2, 0, 1, 0, 0);
        send_frame(2, 0, 0, 1, 0);
        send_frame(2, 0, 0, 0, 1);
        cur_tag = "R8";  pop_n(3);                  // retire first frame
        pop_n(5 + 6 + 6 + 6);
        cur_tag = "R4";  pop_n(2);
        cur_tag = "R7";  pop_n(8);                  // drain and over-pop

        cur_tag = "R2";  send_frame(40, 0, 0, 0, 0); // size 40 -> mod32 8
        pop_n(10);
        cur_tag = "R5";  send_frame(130, 0, 0, 0, 0); // wraps modulo 128
        cur_tag = "R2";  pop_n(30);
        cur_tag = "R8";  pop_n(135);

        cur_tag = "R9";
        for (int f = 0; f < DEPTH; f++) send_frame(2, 0, 0, 0, 0);
        send_frame(3, 0, 1, 1, 1);                  // not tracked
        send_frame(1, 0, 0, 0, 0);                  // not tracked
        pop_n(2);
        send_frame(4, 0, 0, 0, 0);                  // room again
        pop_n(40);

        cur_tag = "R6";
        for (int c = 0; c < 4000; c++) begin
            bit wv = ($urandom % 3) != 0;
            bit wl = wv && (($urandom % 7) == 0);
            if (($urandom % 200) == 0) cfg_fcs_strip = ~cfg_fcs_strip;
            cyc(wv, wl, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, ($urandom % 2) == 0);
        end
        pop_n(300);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule